// File: doc/BRIEF.md
# NAND Flash Register-Window Bridge

This block sits on a simple valid/ready bus as a slave and turns reads and writes on a small byte-addressed window into pin cycles on a raw NAND flash device. The offset of an access alone picks what happens on the pins: a command latch cycle, an address latch cycle, a data write or data read cycle, a blocking poll of the ready/busy line, or the release of chip enable. Software runs the whole flash protocol (command order, ECC, page handling) by writing and reading these offsets in order.

The bridge drives CLE, ALE, CE#, WE# and RE#, an 8-bit I/O output with its own output enable, and samples the 8-bit I/O input and the ready/busy pin. The bus handshake is held off, with `bus_ready` withheld, until every flash cycle that belongs to the access has ended. A 32-bit data read becomes four back-to-back flash read cycles that are packed into the bus word.

Top module: `nand_bus_bridge`

## Requirements
- R1: Offsets decode as 0 = command, 1 = wait, 2 = address, 3 = terminate, 4 = data. Any other offset, a read of offsets 0, 2 or 3, and a write to offset 1 complete with read data zero and no flash cycle.
- R2: A write to offset 0 makes one flash write cycle with CLE = 1, ALE = 0 and `bus_wdata[7:0]` on the I/O output.
- R3: A write to offset 2 makes one flash write cycle with ALE = 1, CLE = 0 and `bus_wdata[7:0]` on the I/O output.
- R4: A write to offset 4 makes one flash write cycle with CLE = 0, ALE = 0 and `bus_wdata[7:0]` on the I/O output. Bits above bit 7 of the write data are not used.
- R5: A byte read (`bus_word` = 0) of offset 4 makes one flash read cycle and returns the sampled byte in `bus_rdata[7:0]` with the upper bits zero.
- R6: A word read (`bus_word` = 1) of offset 4 makes four flash read cycles in a row. The first byte read goes to `bus_rdata[7:0]` and each later byte goes to the next higher lane.
- R7: A read of offset 1 is not completed while the ready/busy input is low. It completes only after the pin has been high through a two-flop synchronizer, so at least three clocks after the pin rises. The returned data is zero.
- R8: CE# is high after reset. It goes low with the first flash cycle after reset or after a terminate and stays low until a write to offset 3, which drives it high whatever the written value.
- R9: In a write cycle, WE# stays low for `WE_LOW` clocks. The data and the output enable are valid for one clock before WE# falls and stay unchanged for one clock after WE# rises.
- R10: In a read cycle, RE# stays low for `RE_LOW` clocks. The I/O input is sampled on the last clock edge before RE# rises, and at least one high clock separates consecutive read strobes.
- R11: The I/O output enable is high only during write cycles. It is never high while RE# is low, and it is low when the bridge is idle.
- R12: `bus_ready` is a one-clock pulse for each accepted access. CLE and ALE are never high together, and WE# and RE# are never low together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Access request, held until `bus_ready` |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 32-bit access, 0 = byte access |
| bus_addr | input | ADDR_W | Byte offset in the register window |
| bus_wdata | input | BUS_W | Write data, byte in bits 7:0 |
| bus_ready | output | 1 | One-clock completion pulse |
| bus_rdata | output | BUS_W | Read data, valid with `bus_ready` |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_io_out | output | 8 | I/O bus output value |
| nf_io_oe | output | 1 | I/O bus output enable |
| nf_io_in | input | 8 | I/O bus input value |
| nf_rb | input | 1 | Flash ready/busy, high = ready |

## Verification
The checker watches the pin rules on every cycle: CLE and ALE are never high together, the strobes never overlap, output enable is never high during a read strobe, the data is held for the clock after WE# rises, CE# is low under any strobe, the ready pulse is one clock long, and a wait access completes only after the synchronized ready/busy was high. The bench scenarios show what depends on values and counts: the latch-line pattern and byte of each write, the strobe widths, how the four read bytes are packed into the lanes, accesses that must leave the pins untouched, the stall length while ready/busy is low, and when CE# is asserted and released across terminate writes.

// File: rtl/nfb_pkg.sv
package nfb_pkg;

   localparam int unsigned OFS_CMD  = 0;
   localparam int unsigned OFS_WAIT = 1;
   localparam int unsigned OFS_ADDR = 2;
   localparam int unsigned OFS_TERM = 3;
   localparam int unsigned OFS_DATA = 4;

   typedef enum logic [2:0] {
      K_NONE, K_CMD, K_ADDR, K_DWR, K_DRD, K_WAIT, K_TERM
   } nfb_kind_t;

   typedef enum logic [2:0] {
      S_IDLE, S_WSET, S_WLOW, S_WHOLD, S_RLOW, S_RREC, S_WAIT, S_DONE
   } nfb_state_t;

endpackage

// File: rtl/nfb_rb_sync.sv
module nfb_rb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);
   logic [STAGES-1:0] chain_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("nfb_rb_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_in};
   end

   assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/nfb_decode.sv
module nfb_decode
   import nfb_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              write,
   output nfb_kind_t         kind
);
   always_comb begin
      kind = K_NONE;
      if (write) begin
         if      (addr == ADDR_W'(OFS_CMD))  kind = K_CMD;
         else if (addr == ADDR_W'(OFS_ADDR)) kind = K_ADDR;
         else if (addr == ADDR_W'(OFS_DATA)) kind = K_DWR;
         else if (addr == ADDR_W'(OFS_TERM)) kind = K_TERM;
      end else begin
         if      (addr == ADDR_W'(OFS_DATA)) kind = K_DRD;
         else if (addr == ADDR_W'(OFS_WAIT)) kind = K_WAIT;
      end
   end
endmodule

// File: rtl/nfb_seq.sv
module nfb_seq
   import nfb_pkg::*;
#(
   parameter int BUS_W  = 32,
   parameter int WE_LOW = 2,
   parameter int RE_LOW = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             word,
   input  nfb_kind_t        kind,
   input  logic [7:0]       wbyte,
   input  logic             rb_s,
   input  logic [7:0]       io_in,
   output logic             done,
   output logic [BUS_W-1:0] rdata,
   output logic             ce_n,
   output logic             cle,
   output logic             ale,
   output logic             we_n,
   output logic             re_n,
   output logic [7:0]       io_out,
   output logic             io_oe
);
   localparam int LANES  = BUS_W / 8;
   localparam int BEAT_W = (LANES > 1) ? $clog2(LANES) : 1;
   localparam int MAXL   = (WE_LOW > RE_LOW) ? WE_LOW : RE_LOW;
   localparam int CNT_W  = $clog2(MAXL + 1);

   nfb_state_t        st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [BEAT_W-1:0] beat_q, last_q;
   logic              cle_q, ale_q, ce_q;
   logic [7:0]        dat_q;
   logic              accept, we_end, re_end;
   logic [7:0]        lane_q [LANES];

   assign accept = (st_q == S_IDLE) && req;
   assign we_end = (cnt_q == CNT_W'(WE_LOW - 1));
   assign re_end = (cnt_q == CNT_W'(RE_LOW - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         cnt_q  <= '0;
         beat_q <= '0;
         last_q <= '0;
         cle_q  <= 1'b0;
         ale_q  <= 1'b0;
         ce_q   <= 1'b0;
         dat_q  <= '0;
      end else begin
         case (st_q)
            S_IDLE: if (req) begin
               cnt_q  <= '0;
               beat_q <= '0;
               case (kind)
                  K_CMD, K_ADDR, K_DWR: begin
                     cle_q <= (kind == K_CMD);
                     ale_q <= (kind == K_ADDR);
                     dat_q <= wbyte;
                     ce_q  <= 1'b1;
                     st_q  <= S_WSET;
                  end
                  K_DRD: begin
                     ce_q   <= 1'b1;
                     last_q <= word ? BEAT_W'(LANES - 1) : '0;
                     st_q   <= S_RLOW;
                  end
                  K_WAIT:  st_q <= S_WAIT;
                  K_TERM: begin
                     ce_q <= 1'b0;
                     st_q <= S_DONE;
                  end
                  default: st_q <= S_DONE;
               endcase
            end
            S_WSET: st_q <= S_WLOW;
            S_WLOW: begin
               if (we_end) begin
                  cnt_q <= '0;
                  st_q  <= S_WHOLD;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            S_WHOLD: begin
               cle_q <= 1'b0;
               ale_q <= 1'b0;
               st_q  <= S_DONE;
            end
            S_RLOW: begin
               if (re_end) begin
                  cnt_q <= '0;
                  st_q  <= S_RREC;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            S_RREC: begin
               if (beat_q == last_q) begin
                  st_q <= S_DONE;
               end else begin
                  beat_q <= beat_q + 1'b1;
                  st_q   <= S_RLOW;
               end
            end
            S_WAIT: if (rb_s) st_q <= S_DONE;
            default: st_q <= S_IDLE;
         endcase
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lane_q[l] <= '0;
         else if (accept)
            lane_q[l] <= '0;
         else if (st_q == S_RLOW && re_end && beat_q == BEAT_W'(l))
            lane_q[l] <= io_in;
      end
      assign rdata[l*8 +: 8] = lane_q[l];
   end

   assign done   = (st_q == S_DONE);
   assign ce_n   = ~ce_q;
   assign cle    = cle_q;
   assign ale    = ale_q;
   assign io_out = dat_q;
   assign we_n   = (st_q != S_WLOW);
   assign re_n   = (st_q != S_RLOW);
   assign io_oe  = (st_q == S_WSET) || (st_q == S_WLOW) || (st_q == S_WHOLD);
endmodule

// File: rtl/nand_bus_bridge.sv
module nand_bus_bridge
   import nfb_pkg::*;
#(
   parameter int ADDR_W    = 3,
   parameter int BUS_W     = 32,
   parameter int WE_LOW    = 2,
   parameter int RE_LOW    = 2,
   parameter int RB_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic              bus_word,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic              bus_ready,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              nf_ce_n,
   output logic              nf_cle,
   output logic              nf_ale,
   output logic              nf_we_n,
   output logic              nf_re_n,
   output logic [7:0]        nf_io_out,
   output logic              nf_io_oe,
   input  logic [7:0]        nf_io_in,
   input  logic              nf_rb
);
   if (ADDR_W < 3) begin : g_bad_addr
      $error("nand_bus_bridge: ADDR_W must reach offset 4");
   end
   if (BUS_W != 32) begin : g_bad_bus
      $error("nand_bus_bridge: BUS_W must be 32");
   end
   if (WE_LOW < 1 || RE_LOW < 1) begin : g_bad_pulse
      $error("nand_bus_bridge: strobe widths must be at least 1");
   end

   logic      rb_s;
   nfb_kind_t kind;

   nfb_rb_sync #(.STAGES(RB_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (nf_rb),
      .d_out (rb_s)
   );

   nfb_decode #(.ADDR_W(ADDR_W)) i_decode (
      .addr  (bus_addr),
      .write (bus_write),
      .kind  (kind)
   );

   nfb_seq #(.BUS_W(BUS_W), .WE_LOW(WE_LOW), .RE_LOW(RE_LOW)) i_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (bus_valid),
      .word   (bus_word),
      .kind   (kind),
      .wbyte  (bus_wdata[7:0]),
      .rb_s   (rb_s),
      .io_in  (nf_io_in),
      .done   (bus_ready),
      .rdata  (bus_rdata),
      .ce_n   (nf_ce_n),
      .cle    (nf_cle),
      .ale    (nf_ale),
      .we_n   (nf_we_n),
      .re_n   (nf_re_n),
      .io_out (nf_io_out),
      .io_oe  (nf_io_oe)
   );
endmodule

// File: rtl/nfb_checker.sv
module nfb_checker #(
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_write,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_ready,
   input logic              nf_ce_n,
   input logic              nf_cle,
   input logic              nf_ale,
   input logic              nf_we_n,
   input logic              nf_re_n,
   input logic [7:0]        nf_io_out,
   input logic              nf_io_oe,
   input logic              rb_s
);
   // R12: latch lines exclusive
   p_latch_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(nf_cle && nf_ale));

   // R12: strobes never overlap
   p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nf_we_n && !nf_re_n));

   // R12: completion is a single-clock pulse
   p_ready_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ready |=> !bus_ready);

   // R11: output enable released under a read strobe
   p_oe_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !nf_re_n |-> !nf_io_oe);

   // R9: data and enable held the clock after WE# rises
   p_we_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nf_we_n) |-> (nf_io_oe && $stable(nf_io_out)));

   // R8: chip enable low under any strobe
   p_ce_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!nf_we_n || !nf_re_n) |-> !nf_ce_n);

   // R7: wait access completes only after synchronized ready
   p_wait_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_ready && bus_valid && !bus_write && bus_addr == ADDR_W'(1))
      |-> $past(rb_s));
endmodule

bind nand_bus_bridge nfb_checker #(.ADDR_W(ADDR_W)) u_nfb_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_valid (bus_valid),
   .bus_write (bus_write),
   .bus_addr  (bus_addr),
   .bus_ready (bus_ready),
   .nf_ce_n   (nf_ce_n),
   .nf_cle    (nf_cle),
   .nf_ale    (nf_ale),
   .nf_we_n   (nf_we_n),
   .nf_re_n   (nf_re_n),
   .nf_io_out (nf_io_out),
   .nf_io_oe  (nf_io_oe),
   .rb_s      (rb_s)
);

// File: tb/test_nand_bus_bridge.sv
module test_nand_bus_bridge;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 3;
   localparam int BUS_W  = 32;
   localparam int WE_LOW = 3;
   localparam int RE_LOW = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_valid = 1'b0, bus_write = 1'b0, bus_word = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [BUS_W-1:0]  bus_wdata = '0;
   logic              bus_ready;
   logic [BUS_W-1:0]  bus_rdata;
   logic              nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_io_oe;
   logic [7:0]        nf_io_out;
   logic [7:0]        nf_io_in = 8'h00;
   logic              nf_rb = 1'b1;

   nand_bus_bridge #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .WE_LOW(WE_LOW), .RE_LOW(RE_LOW))
   i_nand_bus_bridge (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_ready(bus_ready), .bus_rdata(bus_rdata), .nf_ce_n(nf_ce_n),
      .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
      .nf_io_out(nf_io_out), .nf_io_oe(nf_io_oe), .nf_io_in(nf_io_in), .nf_rb(nf_rb)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int fails  = 0;
   logic [9:0]  exp_pin [$];
   string       exp_pin_tag [$];
   logic [31:0] exp_rd [$];
   string       exp_rd_tag [$];

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   // flash model: new byte on each falling read strobe
   function automatic logic [7:0] pat(input int k);
      return 8'(k * 29 + 17);
   endfunction
   int fk = 0;
   always @(negedge nf_re_n) begin
      nf_io_in <= pat(fk);
      fk = fk + 1;
   end
   int ek = 0;

   // monitor: pin events and bus responses
   logic prev_we = 1'b1, prev_re = 1'b1;
   int   wl = 0, rl = 0;
   bit   oe_in_read = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (!nf_we_n) wl++;
         if (!nf_re_n) begin
            rl++;
            if (nf_io_oe) oe_in_read = 1'b1;
         end
         if (!prev_we && nf_we_n) begin
            if (exp_pin.size() == 0) begin
               chk(1'b0, "R1 unexpected write cycle", {22'd0, nf_cle, nf_ale, nf_io_out}, 32'd0);
            end else begin
               logic [9:0] e;
               string t;
               e = exp_pin.pop_front();
               t = exp_pin_tag.pop_front();
               chk({nf_cle, nf_ale, nf_io_out} == e, t, {22'd0, nf_cle, nf_ale, nf_io_out}, {22'd0, e});
            end
            chk(wl == WE_LOW, "R9 WE low width", wl, WE_LOW);
            chk(nf_io_oe == 1'b1, "R9 enable held after WE rise", nf_io_oe, 1);
            chk(nf_ce_n == 1'b0, "R8 CE low in write", nf_ce_n, 0);
            wl = 0;
         end
         if (!prev_re && nf_re_n) begin
            chk(rl == RE_LOW, "R10 RE low width", rl, RE_LOW);
            chk(!oe_in_read, "R11 enable off during read", oe_in_read, 0);
            rl = 0;
            oe_in_read = 1'b0;
         end
         if (bus_ready) begin
            if (exp_rd.size() == 0) begin
               chk(1'b0, "R12 unexpected ready", 0, 1);
            end else begin
               logic [31:0] e;
               string t;
               e = exp_rd.pop_front();
               t = exp_rd_tag.pop_front();
               chk(bus_rdata == e, t, bus_rdata, e);
            end
         end
         prev_we = nf_we_n;
         prev_re = nf_re_n;
      end
   end

   task automatic xfer(input bit wr, input bit wd, input logic [ADDR_W-1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = wr; bus_word = wd; bus_addr = a; bus_wdata = d;
      do @(negedge clk); while (!bus_ready);
      bus_valid = 1'b0;
   endtask

   task automatic wr_reg(input logic [ADDR_W-1:0] a, input logic [31:0] d, input string tag);
      if (a == 0)      begin exp_pin.push_back({2'b10, d[7:0]}); exp_pin_tag.push_back(tag); end
      else if (a == 2) begin exp_pin.push_back({2'b01, d[7:0]}); exp_pin_tag.push_back(tag); end
      else if (a == 4) begin exp_pin.push_back({2'b00, d[7:0]}); exp_pin_tag.push_back(tag); end
      exp_rd.push_back(32'd0); exp_rd_tag.push_back("R12 write response");
      xfer(1'b1, 1'b0, a, d);
   endtask

   task automatic rd_data(input bit wd, input string tag);
      logic [31:0] e;
      e = 32'd0;
      if (wd) begin
         for (int i = 0; i < 4; i++) e[i*8 +: 8] = pat(ek + i);
         ek += 4;
      end else begin
         e[7:0] = pat(ek);
         ek += 1;
      end
      exp_rd.push_back(e); exp_rd_tag.push_back(tag);
      xfer(1'b0, wd, 3'd4, 32'd0);
   endtask

   task automatic rd_other(input logic [ADDR_W-1:0] a, input string tag);
      exp_rd.push_back(32'd0); exp_rd_tag.push_back(tag);
      xfer(1'b0, 1'b1, a, 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(nf_ce_n == 1'b1, "R8 CE high after reset", nf_ce_n, 1);
      chk(nf_we_n && nf_re_n, "R12 strobes idle after reset", {nf_we_n, nf_re_n}, 2'b11);
      chk(nf_io_oe == 1'b0, "R11 enable off when idle", nf_io_oe, 0);
      chk(bus_ready == 1'b0, "R12 no ready after reset", bus_ready, 0);

      wr_reg(3'd0, 32'h0000_0070, "R2 command cycle");
      @(negedge clk);
      chk(nf_ce_n == 1'b0, "R8 CE low after first cycle", nf_ce_n, 0);
      chk(nf_io_oe == 1'b0, "R11 enable off after write", nf_io_oe, 0);
      wr_reg(3'd2, 32'h0000_0012, "R3 address cycle");
      wr_reg(3'd2, 32'hFFFF_FF34, "R3 address cycle upper bits");
      wr_reg(3'd4, 32'hDEAD_BEA5, "R4 data write cycle");
      wr_reg(3'd0, 32'h0000_00FF, "R2 command cycle 2");

      rd_data(1'b0, "R5 byte read 1");
      rd_data(1'b0, "R5 byte read 2");
      rd_data(1'b1, "R6 word read lanes 1");
      rd_data(1'b1, "R6 word read lanes 2");
      rd_data(1'b0, "R5 byte read after word");

      wr_reg(3'd5, 32'h0000_0055, "R1 unmapped write 5");
      wr_reg(3'd7, 32'h0000_0066, "R1 unmapped write 7");
      wr_reg(3'd1, 32'h0000_0077, "R1 write to wait offset");
      rd_other(3'd6, "R1 unmapped read");
      rd_other(3'd0, "R1 read of command offset");
      rd_other(3'd3, "R1 read of terminate offset");
      @(negedge clk);
      chk(nf_ce_n == 1'b0, "R1 CE unchanged by unmapped", nf_ce_n, 0);

      rd_other(3'd1, "R7 wait read while ready");

      nf_rb = 1'b0;
      @(negedge clk);
      exp_rd.push_back(32'd0); exp_rd_tag.push_back("R7 wait read data");
      fork
         xfer(1'b0, 1'b0, 3'd1, 32'd0);
         begin
            bit early;
            early = 1'b0;
            repeat (20) begin
               @(negedge clk);
               if (bus_ready) early = 1'b1;
            end
            chk(!early, "R7 stall while busy", early, 0);
            nf_rb = 1'b1;
            early = 1'b0;
            repeat (2) begin
               @(negedge clk);
               if (bus_ready) early = 1'b1;
            end
            chk(!early, "R7 synchronizer delay", early, 0);
         end
      join

      wr_reg(3'd3, 32'h0000_00FF, "R8 terminate response");
      @(negedge clk);
      chk(nf_ce_n == 1'b1, "R8 CE high after terminate", nf_ce_n, 1);
      rd_data(1'b0, "R8 read after terminate");
      @(negedge clk);
      chk(nf_ce_n == 1'b0, "R8 CE low again after read", nf_ce_n, 0);
      wr_reg(3'd3, 32'h0000_0000, "R8 terminate zero value");
      @(negedge clk);
      chk(nf_ce_n == 1'b1, "R8 CE high after second terminate", nf_ce_n, 1);
      wr_reg(3'd4, 32'h0000_003C, "R4 data write after terminate");
      @(negedge clk);
      chk(nf_ce_n == 1'b0, "R8 CE low after write", nf_ce_n, 0);

      repeat (4) @(negedge clk);
      chk(exp_pin.size() == 0, "R1 all pin cycles seen", exp_pin.size(), 0);
      chk(exp_rd.size() == 0, "R12 all responses seen", exp_rd.size(), 0);
      chk(fk == ek, "R10 read strobe count", fk, ek);
      finish_run();
   end
endmodule